// File: doc/BRIEF.md
# Alarm change-detect event register

This block sits beside a receive-side high-speed framer. The framer supplies eight alarm state levels. The block turns each level into a sticky event flag that is raised whenever that level changes, in either direction. The eight alarms are:

- loss of input clock
- out of frame
- loss of frame
- loss of signal
- signal degrade
- signal fail
- trace identifier mismatch
- overhead monitor byte update

The loss-of-signal flag has a second source. It is an asynchronous board pin, which is brought into the clock domain through a flop chain before its edges are detected.

Software reaches the block through a small register port:

- Reading one address returns the event byte.
- A second address holds a per-bit mask.
- Any unmasked pending event raises a single interrupt line.

The `clear_by_write` input selects how flags are acknowledged:

- In clear-on-read mode, a read of the event byte empties it.
- In clear-on-write mode, software writes ones to the flags it has handled.

A change that lands in the same cycle as an acknowledge is never lost.

Top module: `alarm_delta_reg`

## Requirements
- R1: Event bit i follows `alarm_st[i]`, with this fixed assignment: bit 0 clock loss, bit 1 out of frame, bit 2 loss of frame, bit 3 loss of signal, bit 4 degrade, bit 5 fail, bit 6 trace mismatch, bit 7 monitor update. The event byte is read at address 0.
- R2: While reset is active, the event byte reads 0x00, the mask reads 0xFF and `irq` is 0.
- R3: A change of `alarm_st[i]` in either direction, present before a rising edge, sets event bit i at that edge. Levels already present at reset release raise no event.
- R4: An event bit stays set after its alarm returns to its earlier level, until it is cleared through the register port.
- R5: Event bit 3 is also set by either edge of `los_pin_async`. The bit appears at the third rising clock edge after the pin changes, and not earlier.
- R6: With `clear_by_write`=0, a read of address 0 returns the event byte and clears all of its bits at that edge. Writes to address 0 have no effect.
- R7: With `clear_by_write`=1, a write to address 0 clears exactly the bits written as 1. Bits written as 0 are left unchanged, and reads do not clear.
- R8: If a change arrives in the same cycle as a clear of its bit, the bit remains set.
- R9: Address 1 is the mask register and can be read and written. Addresses 2 and 3 read as 0x00.
- R10: `irq` is 1 exactly when at least one event bit is set whose mask bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| alarm_st | input | 8 | Alarm state levels from the framer, synchronous to `clk` |
| los_pin_async | input | 1 | External loss-of-signal level, asynchronous |
| clear_by_write | input | 1 | Acknowledge mode: 0 clears on read, 1 clears on write |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address (0 events, 1 mask) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from the address |
| irq | output | 1 | Interrupt, high while any unmasked event is pending |

## Verification
The bench builds the block with its defaults: a two-bit address, two synchroniser stages on the pin and two stages on reset release. The two-bit address brings the unmapped addresses 2 and 3 within reach. The two-stage pin chain makes the three-edge latency of the pin path observable edge by edge. Both acknowledge modes are exercised on one instance by switching `clear_by_write` between scenarios. The collision of a change with a clear is tested in both modes.

// File: rtl/alarm_delta_pkg.sv
package alarm_delta_pkg;

  localparam int unsigned ALARM_COUNT = 8;

  // Fixed event bit assignment (software decodes these positions)
  localparam int unsigned IDX_CLK_LOSS   = 0;
  localparam int unsigned IDX_OOF        = 1;
  localparam int unsigned IDX_LOF        = 2;
  localparam int unsigned IDX_LOS        = 3;
  localparam int unsigned IDX_DEGRADE    = 4;
  localparam int unsigned IDX_FAIL       = 5;
  localparam int unsigned IDX_TRACE_MISM = 6;
  localparam int unsigned IDX_MON_UPDATE = 7;

  // Register offsets
  localparam int unsigned DELTA_OFS = 0;
  localparam int unsigned MASK_OFS  = 1;

  typedef enum logic {
    CLR_ON_READ  = 1'b0,
    CLR_ON_WRITE = 1'b1
  } clr_mode_e;

  typedef logic [ALARM_COUNT-1:0] alarm_vec_t;

endpackage

// File: rtl/alarm_sync_chain.sv
module alarm_sync_chain #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);

  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  generate
    if (STAGES == 1) begin : g_single
      assign stage_d = async_in;
    end else begin : g_multi
      assign stage_d = {stage_q[STAGES-2:0], async_in};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/alarm_change_det.sv
module alarm_change_det #(
  parameter int unsigned WIDTH     = 8,
  parameter int unsigned ARM_DELAY = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] level_in,
  output logic [WIDTH-1:0] change_o
);

  localparam int unsigned CNT_W = $clog2(ARM_DELAY + 1);

  logic [WIDTH-1:0] prev_q;
  logic [CNT_W-1:0] arm_cnt_q;
  logic [CNT_W-1:0] arm_cnt_d;
  logic             armed;
  logic             arm_cnt_en;

  // Compare only once the reference level is trustworthy
  always_comb begin
    armed      = (arm_cnt_q == CNT_W'(ARM_DELAY));
    arm_cnt_en = !armed;
    arm_cnt_d  = arm_cnt_q + CNT_W'(1);
    change_o   = armed ? (level_in ^ prev_q) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q    <= '0;
      arm_cnt_q <= '0;
    end else begin
      prev_q <= level_in;
      if (arm_cnt_en) begin
        arm_cnt_q <= arm_cnt_d;
      end
    end
  end

endmodule

// File: rtl/alarm_sticky_bank.sv
module alarm_sticky_bank #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] flags_o
);

  logic [WIDTH-1:0] flag_q;
  logic [WIDTH-1:0] flag_d;

  // Set has priority over a simultaneous clear
  generate
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
      assign flag_d[g] = set_i[g] | (flag_q[g] & ~clr_i[g]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign flags_o = flag_q;

endmodule

// File: rtl/alarm_delta_reg.sv
module alarm_delta_reg
  import alarm_delta_pkg::*;
#(
  parameter int unsigned ADDR_W          = 2,
  parameter int unsigned SYNC_STAGES     = 2,
  parameter int unsigned RST_SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ALARM_COUNT-1:0] alarm_st,
  input  logic                   los_pin_async,
  input  logic                   clear_by_write,
  input  logic                   reg_rd,
  input  logic                   reg_wr,
  input  logic [ADDR_W-1:0]      reg_addr,
  input  logic [ALARM_COUNT-1:0] reg_wdata,
  output logic [ALARM_COUNT-1:0] reg_rdata,
  output logic                   irq
);

  localparam int unsigned DW        = ALARM_COUNT;
  localparam int unsigned PIN_ARM   = SYNC_STAGES + 1;

  logic       core_rst_n;
  logic       los_pin_sync;
  alarm_vec_t change_int;
  logic [0:0] change_pin;
  alarm_vec_t pin_set;
  alarm_vec_t set_vec;
  alarm_vec_t clr_vec;
  alarm_vec_t delta_q;
  alarm_vec_t mask_q;
  alarm_vec_t mask_d;
  logic       mask_we;
  logic       hit_delta;
  logic       hit_mask;
  clr_mode_e  clr_mode;

  // Reset: asserted asynchronously, released on a clock edge
  alarm_sync_chain #(.STAGES(RST_SYNC_STAGES)) u_rst_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (1'b1),
    .sync_out (core_rst_n)
  );

  // External loss-of-signal pin into the clock domain
  alarm_sync_chain #(.STAGES(SYNC_STAGES)) u_pin_sync (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .async_in (los_pin_async),
    .sync_out (los_pin_sync)
  );

  alarm_change_det #(.WIDTH(DW), .ARM_DELAY(1)) u_int_det (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .level_in (alarm_st),
    .change_o (change_int)
  );

  // Armed only after the synchroniser has filled with the real pin level
  alarm_change_det #(.WIDTH(1), .ARM_DELAY(PIN_ARM)) u_pin_det (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .level_in (los_pin_sync),
    .change_o (change_pin)
  );

  always_comb begin
    pin_set          = '0;
    pin_set[IDX_LOS] = change_pin[0];
    set_vec          = change_int | pin_set;
  end

  // Register port decode and acknowledge
  always_comb begin
    clr_mode  = clr_mode_e'(clear_by_write);
    hit_delta = (reg_addr == ADDR_W'(DELTA_OFS));
    hit_mask  = (reg_addr == ADDR_W'(MASK_OFS));
    clr_vec   = '0;
    unique case (clr_mode)
      CLR_ON_WRITE: if (reg_wr && hit_delta) clr_vec = reg_wdata;
      CLR_ON_READ:  if (reg_rd && hit_delta) clr_vec = '1;
      default:      clr_vec = '0;
    endcase
  end

  alarm_sticky_bank #(.WIDTH(DW)) u_bank (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .set_i   (set_vec),
    .clr_i   (clr_vec),
    .flags_o (delta_q)
  );

  // Mask register
  always_comb begin
    mask_we = reg_wr && hit_mask;
    mask_d  = reg_wdata;
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      mask_q <= '1;
    end else if (mask_we) begin
      mask_q <= mask_d;
    end
  end

  // Read data and interrupt
  always_comb begin
    reg_rdata = '0;
    if (hit_delta) begin
      reg_rdata = delta_q;
    end else if (hit_mask) begin
      reg_rdata = mask_q;
    end
    irq = |(delta_q & ~mask_q);
  end

endmodule

// File: rtl/alarm_delta_reg_chk.sv
module alarm_delta_reg_chk
  import alarm_delta_pkg::*;
#(
  parameter int unsigned ADDR_W = 2
) (
  input logic                   clk,
  input logic                   core_rst_n,
  input logic [ALARM_COUNT-1:0] set_vec,
  input logic [ALARM_COUNT-1:0] delta_q,
  input logic [ALARM_COUNT-1:0] mask_q,
  input logic                   irq,
  input logic                   reg_rd,
  input logic                   reg_wr,
  input logic [ADDR_W-1:0]      reg_addr,
  input logic [ALARM_COUNT-1:0] reg_wdata,
  input logic                   clear_by_write
);

  logic at_delta;
  logic at_mask;
  assign at_delta = (reg_addr == ADDR_W'(DELTA_OFS));
  assign at_mask  = (reg_addr == ADDR_W'(MASK_OFS));

  a_r2_reset_state: assert property (@(posedge clk) disable iff (!core_rst_n)
    $rose(core_rst_n) |-> (delta_q == '0 && mask_q == '1 && !irq));

  a_r8_set_wins: assert property (@(posedge clk) disable iff (!core_rst_n)
    1'b1 |=> ((delta_q & $past(set_vec)) == $past(set_vec)));

  a_r4_sticky_idle: assert property (@(posedge clk) disable iff (!core_rst_n)
    (!reg_rd && !reg_wr) |=> ((delta_q & $past(delta_q)) == $past(delta_q)));

  a_r6_read_clears: assert property (@(posedge clk) disable iff (!core_rst_n)
    (reg_rd && at_delta && !clear_by_write && set_vec == '0) |=> (delta_q == '0));

  a_r7_write_clears: assert property (@(posedge clk) disable iff (!core_rst_n)
    (reg_wr && at_delta && clear_by_write && set_vec == '0)
      |=> ((delta_q & $past(reg_wdata)) == '0));

  a_r9_mask_write: assert property (@(posedge clk) disable iff (!core_rst_n)
    (reg_wr && at_mask) |=> (mask_q == $past(reg_wdata)));

  a_r10_irq_rise_cause: assert property (@(posedge clk) disable iff (!core_rst_n)
    $rose(irq) |-> $past(set_vec != '0 || reg_wr));

  a_r10_irq_quiet: assert property (@(posedge clk) disable iff (!core_rst_n)
    (!reg_rd && !reg_wr && set_vec == '0) |=> $stable(irq));

endmodule

bind alarm_delta_reg alarm_delta_reg_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk            (clk),
  .core_rst_n     (core_rst_n),
  .set_vec        (set_vec),
  .delta_q        (delta_q),
  .mask_q         (mask_q),
  .irq            (irq),
  .reg_rd         (reg_rd),
  .reg_wr         (reg_wr),
  .reg_addr       (reg_addr),
  .reg_wdata      (reg_wdata),
  .clear_by_write (clear_by_write)
);

// File: tb/tb_alarm_delta_reg.sv
`timescale 1ns/1ps
module tb_alarm_delta_reg;

  logic       clk;
  logic       rst_n;
  logic [7:0] alarm_st;
  logic       los_pin_async;
  logic       clear_by_write;
  logic       reg_rd;
  logic       reg_wr;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  alarm_delta_reg dut (
    .clk(clk), .rst_n(rst_n), .alarm_st(alarm_st), .los_pin_async(los_pin_async),
    .clear_by_write(clear_by_write), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [7:0] got, input logic [7:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, got, exp);
    end
  endtask

  task automatic finish_sim();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic do_write(input logic [1:0] a, input logic [7:0] d);
    reg_addr  = a;
    reg_wdata = d;
    reg_wr    = 1'b1;
    step(1);
    reg_wr    = 1'b0;
  endtask

  task automatic do_read(input logic [1:0] a, output logic [7:0] v);
    reg_addr = a;
    reg_rd   = 1'b1;
    #1;
    v = reg_rdata;
    @(posedge clk);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  // R2, R3, R9: reset state and no event from levels held through reset
  task automatic t_reset();
    logic [7:0] v;
    rst_n = 1'b0; alarm_st = 8'h55; los_pin_async = 1'b1; clear_by_write = 1'b1;
    reg_rd = 1'b0; reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = 8'h00;
    repeat (5) @(negedge clk);
    peek(2'd0, v); check("R2", "event byte in reset", v, 8'h00);
    peek(2'd1, v); check("R2", "mask in reset", v, 8'hFF);
    check("R2", "irq in reset", {7'b0, irq}, 8'h00);
    rst_n = 1'b1;
    step(12);
    peek(2'd0, v); check("R3", "no event from reset levels", v, 8'h00);
    peek(2'd2, v); check("R9", "address 2 reads zero", v, 8'h00);
    peek(2'd3, v); check("R9", "address 3 reads zero", v, 8'h00);
  endtask

  // R1, R3, R7: each bit, both directions
  task automatic t_each_bit();
    logic [7:0] v;
    for (int i = 0; i < 8; i++) begin
      for (int dir = 0; dir < 2; dir++) begin
        alarm_st = alarm_st ^ (8'h01 << i);
        step(1);
        peek(2'd0, v); check("R1", "bit position after change", v, 8'h01 << i);
        do_write(2'd0, 8'h01 << i);
        peek(2'd0, v); check("R7", "write-one clears bit", v, 8'h00);
      end
    end
  endtask

  // R4: sticky after alarm returns; R7: read does not clear
  task automatic t_sticky();
    logic [7:0] v;
    alarm_st = alarm_st ^ 8'h04; step(1);
    alarm_st = alarm_st ^ 8'h04; step(4);
    peek(2'd0, v); check("R4", "bit held after alarm returns", v, 8'h04);
    do_read(2'd0, v); check("R7", "read value in write mode", v, 8'h04);
    peek(2'd0, v); check("R7", "read leaves bit in write mode", v, 8'h04);
    do_write(2'd0, 8'h04);
  endtask

  // R7: only bits written as one are cleared
  task automatic t_cow_partial();
    logic [7:0] v;
    alarm_st = alarm_st ^ 8'h0F; step(1);
    peek(2'd0, v); check("R7", "four pending", v, 8'h0F);
    do_write(2'd0, 8'h05);
    peek(2'd0, v); check("R7", "partial clear", v, 8'h0A);
    do_write(2'd0, 8'h00);
    peek(2'd0, v); check("R7", "zero write no effect", v, 8'h0A);
    do_write(2'd0, 8'h0A);
    peek(2'd0, v); check("R7", "rest cleared", v, 8'h00);
  endtask

  // R6: clear on read, writes ignored
  task automatic t_cor();
    logic [7:0] v;
    clear_by_write = 1'b0;
    alarm_st = alarm_st ^ 8'h30; step(1);
    do_write(2'd0, 8'hFF);
    peek(2'd0, v); check("R6", "write ignored in read mode", v, 8'h30);
    do_read(2'd0, v); check("R6", "read returns events", v, 8'h30);
    peek(2'd0, v); check("R6", "read cleared events", v, 8'h00);
    alarm_st = alarm_st ^ 8'h01; step(1);
    do_read(2'd1, v); check("R6", "mask read value", v, 8'hFF);
    peek(2'd0, v); check("R6", "mask read does not clear", v, 8'h01);
    do_read(2'd0, v);
    clear_by_write = 1'b1;
  endtask

  // R8: change coinciding with clear, both modes
  task automatic t_set_wins();
    logic [7:0] v;
    alarm_st = alarm_st ^ 8'h02;
    do_write(2'd0, 8'h02);
    peek(2'd0, v); check("R8", "set beats write clear", v, 8'h02);
    do_write(2'd0, 8'h02);
    clear_by_write = 1'b0;
    alarm_st = alarm_st ^ 8'h80;
    do_read(2'd0, v); check("R8", "read value before set", v, 8'h00);
    peek(2'd0, v); check("R8", "set beats read clear", v, 8'h80);
    do_read(2'd0, v); check("R6", "read returns late set", v, 8'h80);
    peek(2'd0, v); check("R6", "cleared after read", v, 8'h00);
    clear_by_write = 1'b1;
  endtask

  // R5: external pin latency, both edges
  task automatic t_los_pin();
    logic [7:0] v;
    for (int k = 0; k < 2; k++) begin
      los_pin_async = ~los_pin_async;
      repeat (2) @(posedge clk);
      @(negedge clk);
      peek(2'd0, v); check("R5", "pin not yet seen after two edges", v, 8'h00);
      step(1);
      peek(2'd0, v); check("R5", "pin seen at third edge", v, 8'h08);
      do_write(2'd0, 8'h08);
    end
  endtask

  // R9, R10: mask and interrupt
  task automatic t_irq();
    logic [7:0] v;
    alarm_st = alarm_st ^ 8'h08; step(1);
    check("R10", "irq masked", {7'b0, irq}, 8'h00);
    do_write(2'd1, 8'hF7);
    peek(2'd1, v); check("R9", "mask readback", v, 8'hF7);
    check("R10", "irq unmasked bit", {7'b0, irq}, 8'h01);
    do_write(2'd1, 8'hFF);
    check("R10", "irq remasked", {7'b0, irq}, 8'h00);
    do_write(2'd1, 8'h00);
    check("R10", "irq all unmasked", {7'b0, irq}, 8'h01);
    do_write(2'd0, 8'h08);
    check("R10", "irq after clear", {7'b0, irq}, 8'h00);
    do_write(2'd1, 8'hFF);
  endtask

  initial begin
    t_reset();
    t_each_bit();
    t_sticky();
    t_cow_partial();
    t_cor();
    t_set_wins();
    t_los_pin();
    t_irq();
    finish_sim();
  end

  initial begin
    #2000000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_sim();
  end

endmodule